// File: doc/BRIEF.md
# Clock-Synthesizer Serial Configuration Slave

This block is the two-wire serial slave of a clock synthesizer. It watches an SCL/SDA bus through a synchronizer. It recognises start and stop conditions, its own device address, and the bytes that follow. It answers on SDA only by pulling the line low through an open-drain enable. A write moves configuration bytes into a small register bank. A read hands the bank back to the master.

The bank sets the control lines of the synthesizer: a 3-bit frequency code, the source of that code, the spread-spectrum type and enable, and a tristate request for all clock outputs. The frequency code either comes from strap pins, which are captured once after reset, or from the register. Register byte 0 chooses between the two.

Every write carries two leading bytes (a command code and a byte count) that the slave acknowledges and throws away. Only the bytes after them are stored, starting at register 0. Every read opens with a count byte before the register contents.

Top module: `synth_cfg_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0x69: the write byte 0xD2 and the read byte 0xD3 are acknowledged. Any other address is not acknowledged, and the slave keeps SDA released and leaves the registers unchanged until the next start.
- R2: An accepted byte is acknowledged by holding SDA low through the high phase of the ninth SCL pulse. The slave changes its SDA drive only while SCL is low.
- R3: In a write, the first two bytes after the address are acknowledged and discarded, and no register changes.
- R4: Write data bytes are stored in order from register 0 (register k gets the k-th data byte). Bytes beyond the last register (NUM_REGS, default 1) are acknowledged and have no effect. A register changes only through such a write.
- R5: A write that ends with a stop right after the two discarded bytes leaves every register unchanged.
- R6: In a read, the first byte returned is NUM_REGS (0x01 by default), followed by register 0 onward, MSB first. Reads past the last register return 0x00.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and stays silent until the next start. A master acknowledge makes it send the next byte.
- R8: A stop condition returns the slave to idle with SDA released. A repeated start begins a new address phase.
- R9: Reset clears all register bits to 0 and releases SDA.
- R10: The strap pins hw_sel are captured on the first clock after reset release. Later changes on hw_sel have no effect.
- R11: Register 0 bit fields: bit 3 = source (1: freq_code = bits 6:4, 0: freq_code = the captured straps), bit 2 = spread_down, bit 1 = spread_en, bit 0 = outputs_tristate. Bit 7 is stored and read back but drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| hw_sel | input | 3 | Frequency strap pins |
| freq_code | output | 3 | Effective frequency select code |
| freq_from_reg | output | 1 | 1 when the code comes from the register |
| spread_down | output | 1 | Spread type: 1 down-spread, 0 center-spread |
| spread_en | output | 1 | Spread-spectrum enable |
| outputs_tristate | output | 1 | Request to tristate all clock outputs |

## Verification
Two functions can fall in the same update: the register write flips the code source from straps to register, and it loads a new code from that same byte. The bench toggles the strap pins just before sending a byte that sets both at once. It then checks that freq_code lands on the written code and not on a blend or the live pins. A later write clears only the source bit. The bench checks that the code then falls back to the straps captured at reset, not to the pins' current value.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 3;

  // bit positions inside configuration register 0 (decoded by the synthesizer)
  localparam int F_TRI     = 0;
  localparam int F_SS_EN   = 1;
  localparam int F_SS_DOWN = 2;
  localparam int F_SRC     = 3;
  localparam int F_CODE_LO = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_e;

  typedef enum logic {
    K_ADDR,
    K_DATA
  } byte_kind_e;

  // effective code: register field when the source bit is set, straps otherwise
  function automatic logic [CODE_W-1:0] pick_code(
    input logic [BYTE_W-1:0] cfg,
    input logic [CODE_W-1:0] strap
  );
    return cfg[F_SRC] ? cfg[F_CODE_LO +: CODE_W] : strap;
  endfunction

  function automatic logic [BYTE_W-1:0] sat_inc(input logic [BYTE_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    // STAGES synchronizer flops plus one history flop for edges
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], raw[g]};
    end

    assign level[g] = pipe[STAGES-1];
    assign rise[g]  =  pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[g]  = ~pipe[STAGES-1] &  pipe[STAGES];
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int NUM_REGS = 1
)(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [synth_cfg_pkg::BYTE_W-1:0]    widx,
  input  logic [synth_cfg_pkg::BYTE_W-1:0]    wdata,
  input  logic [synth_cfg_pkg::BYTE_W-1:0]    ridx,
  output logic [synth_cfg_pkg::BYTE_W-1:0]    rdata,
  input  logic [synth_cfg_pkg::CODE_W-1:0]    hw_sel,
  output logic [synth_cfg_pkg::CODE_W-1:0]    freq_code,
  output logic                                src_reg,
  output logic                                ss_down,
  output logic                                ss_en,
  output logic                                tri_all
);
  import synth_cfg_pkg::*;

  logic [BYTE_W-1:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bank[g] <= '0;
      else if (we && widx == 8'(g))     bank[g] <= wdata;
    end

    // a register only moves after a write aimed at it
    assert_bank_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bank[g] != $past(bank[g])) |-> ($past(we) && $past(widx) == 8'(g)));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ridx == 8'(i)) rdata = bank[i];
  end

  // strap capture: once, on the first clock after reset release
  logic              strap_taken;
  logic [CODE_W-1:0] strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_taken <= 1'b0;
      strap_q     <= '0;
    end else if (!strap_taken) begin
      strap_taken <= 1'b1;
      strap_q     <= hw_sel;
    end
  end

  assert_strap_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_taken && $past(strap_taken)) |-> $stable(strap_q));

  assign freq_code = pick_code(bank[0], strap_q);
  assign src_reg   = bank[0][F_SRC];
  assign ss_down   = bank[0][F_SS_DOWN];
  assign ss_en     = bank[0][F_SS_EN];
  assign tri_all   = bank[0][F_TRI];

endmodule

// File: rtl/synth_cfg_slave.sv
module synth_cfg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 1,
  parameter int         SYNC_STAGES = 2
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             scl_i,
  input  logic                             sda_i,
  output logic                             sda_oe,
  input  logic [synth_cfg_pkg::CODE_W-1:0] hw_sel,
  output logic [synth_cfg_pkg::CODE_W-1:0] freq_code,
  output logic                             freq_from_reg,
  output logic                             spread_down,
  output logic                             spread_en,
  output logic                             outputs_tristate
);
  import synth_cfg_pkg::*;

  localparam logic [BYTE_W-1:0] COUNT_BYTE = 8'(NUM_REGS);
  localparam int                SKIP_BYTES = 2;

  // ---------------- line conditioning ----------------
  logic [1:0] lvl, rse, fal;

  bus_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({sda_i, scl_i}),
    .level (lvl),
    .rise  (rse),
    .fall  (fal)
  );

  // named bus events
  logic scl_hi, scl_rise, scl_fall, sda_lvl, start_evt, stop_evt;
  assign scl_hi    = lvl[0];
  assign scl_rise  = rse[0];
  assign scl_fall  = fal[0];
  assign sda_lvl   = lvl[1];
  assign start_evt = fal[1] & scl_hi;
  assign stop_evt  = rse[1] & scl_hi;

  // ---------------- sequencer state ----------------
  bus_state_e        state;
  byte_kind_e        kind;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] wr_seen;
  logic [BYTE_W-1:0] rd_idx;
  logic              rw_read;
  logic              mack_nack;

  logic              byte_done, addr_match, reg_we, nack_evt;
  logic [BYTE_W-1:0] rd_data, next_rd, rd_ridx, wr_widx;

  assign byte_done  = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign addr_match = (shreg[7:1] == DEV_ADDR);
  assign reg_we     = byte_done && (kind == K_DATA) && (wr_seen >= 8'(SKIP_BYTES));
  assign wr_widx    = wr_seen - 8'(SKIP_BYTES);
  assign nack_evt   = (state == ST_MACK) && scl_fall && mack_nack;
  assign rd_ridx    = rd_idx - 8'd1;
  assign next_rd    = (rd_idx == '0) ? COUNT_BYTE : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      wr_seen   <= '0;
      rd_idx    <= '0;
      rw_read   <= 1'b0;
      mack_nack <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_RX;
      kind    <= K_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (kind == K_ADDR && !addr_match) begin
              state <= ST_IDLE;
            end else begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
              if (kind == K_ADDR) begin
                rw_read <= shreg[0];
                wr_seen <= '0;
                rd_idx  <= '0;
              end else begin
                wr_seen <= sat_inc(wr_seen);
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_read) begin
              state  <= ST_TX;
              tx_sh  <= next_rd;
              sda_oe <= ~next_rd[7];
              rd_idx <= sat_inc(rd_idx);
            end else begin
              state  <= ST_RX;
              kind   <= K_DATA;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              state  <= ST_MACK;
              sda_oe <= 1'b0;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_nack <= sda_lvl;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (mack_nack) begin
              state <= ST_IDLE;
            end else begin
              state  <= ST_TX;
              tx_sh  <= next_rd;
              sda_oe <= ~next_rd[7];
              rd_idx <= sat_inc(rd_idx);
            end
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- register bank and code source ----------------
  cfg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .widx      (wr_widx),
    .wdata     (shreg),
    .ridx      (rd_ridx),
    .rdata     (rd_data),
    .hw_sel    (hw_sel),
    .freq_code (freq_code),
    .src_reg   (freq_from_reg),
    .ss_down   (spread_down),
    .ss_en     (spread_en),
    .tri_all   (outputs_tristate)
  );

  // ---------------- assertions ----------------
  assert_addr_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK && $past(state) == ST_RX && $past(kind) == K_ADDR)
      |-> ($past(shreg[7:1]) == DEV_ADDR));

  assert_sda_quiet_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi)) |-> $stable(sda_oe));

  assert_write_after_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (!rw_read && kind == K_DATA));

  assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> (state == ST_IDLE && !sda_oe));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: tb/synth_cfg_slave_test.sv
module synth_cfg_slave_test;

  localparam int Q = 10;   // system clocks per quarter SCL bit

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       sda_oe;
  logic [2:0] hw_sel;
  logic [2:0] freq_code;
  logic       freq_from_reg, spread_down, spread_en, outputs_tristate;
  wire        sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  synth_cfg_slave uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .scl_i            (m_scl),
    .sda_i            (sda_bus),
    .sda_oe           (sda_oe),
    .hw_sel           (hw_sel),
    .freq_code        (freq_code),
    .freq_from_reg    (freq_from_reg),
    .spread_down      (spread_down),
    .spread_en        (spread_en),
    .outputs_tristate (outputs_tristate)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pairs each byte read off the bus with its expectation
  always @(negedge clk) begin : monitor
    logic [7:0] g, e;
    string t;
    if (got_q.size() != 0) begin
      g = got_q.pop_front();
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected byte actual=%0h expected=none", g);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(g), 32'(e));
      end
    end
  end

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; half();
    m_scl = 1'b1; half();
    m_sda = 1'b0; half();
    m_scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; half();
    m_scl = 1'b1; half();
    m_sda = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; half();
      m_scl = 1'b1; half(); half();
      m_scl = 1'b0; half();
    end
    m_sda = 1'b1; half();
    m_scl = 1'b1; half();
    acked = (sda_bus == 1'b0);
    half();
    m_scl = 1'b0; half();
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half();
      m_scl = 1'b1; half();
      b[i] = sda_bus;
      half();
      m_scl = 1'b0; half();
    end
    m_sda = ack_it ? 1'b0 : 1'b1; half();
    m_scl = 1'b1; half(); half();
    m_scl = 1'b0; half();
    m_sda = 1'b1;
  endtask

  // driver side of the scoreboard
  task automatic rd_expect(input logic [7:0] exp, input logic ack_it, input string tag);
    logic [7:0] b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    recv_byte(ack_it, b);
    got_q.push_back(b);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic       ack;
    logic [7:0] b;
    m_scl = 1'b1; m_sda = 1'b1;
    hw_sel = 3'b101;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 sda_oe", 32'(sda_oe), 32'd0);
    chk("R9 config", {27'd0, freq_from_reg, spread_down, spread_en, outputs_tristate, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 strap captured", 32'(freq_code), 32'h5);
    hw_sel = 3'b010;
    repeat (5) @(negedge clk);
    chk("R10 strap change ignored", 32'(freq_code), 32'h5);

    // write: address, two skipped bytes, data byte, one extra byte
    bus_start();
    send_byte(8'hD2, ack);  chk("R1 write address ack", 32'(ack), 32'd1);
    send_byte(8'h3F, ack);  chk("R2 ack skipped byte 1", 32'(ack), 32'd1);
    send_byte(8'hFF, ack);  chk("R3 ack skipped byte 2", 32'(ack), 32'd1);
    chk("R3 skipped bytes not stored", {28'd0, freq_from_reg, spread_down, spread_en, outputs_tristate}, 32'd0);
    hw_sel = 3'b111;   // straps move while the source switches
    send_byte(8'hBE, ack);  chk("R2 ack data byte", 32'(ack), 32'd1);
    chk("R11 code from register", 32'(freq_code), 32'h3);
    chk("R11 fields", {28'd0, freq_from_reg, spread_down, spread_en, outputs_tristate}, 32'hE);
    send_byte(8'h00, ack);  chk("R4 byte past bank acked", 32'(ack), 32'd1);
    chk("R4 byte past bank ignored", 32'(freq_code), 32'h3);
    bus_stop();
    chk("R8 idle after stop", 32'(sda_oe), 32'd0);

    // read: count, register 0, beyond the bank, then nack
    bus_start();
    send_byte(8'hD3, ack);  chk("R1 read address ack", 32'(ack), 32'd1);
    rd_expect(8'h01, 1'b1, "R6 count byte");
    rd_expect(8'hBE, 1'b1, "R6 register 0 R4 order");
    rd_expect(8'h00, 1'b0, "R6 past bank");
    recv_byte(1'b0, b);
    chk("R7 silent after nack", 32'(b), 32'hFF);
    bus_stop();

    // foreign address
    bus_start();
    send_byte(8'hA4, ack);  chk("R1 foreign address no ack", 32'(ack), 32'd0);
    send_byte(8'h00, ack);  chk("R1 silent after foreign address", 32'(ack), 32'd0);
    bus_stop();
    chk("R1 registers untouched", 32'(freq_code), 32'h3);

    // write with no data bytes
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    bus_stop();
    chk("R5 empty write", {25'd0, freq_code, freq_from_reg, spread_down, spread_en, outputs_tristate}, 32'h3E);

    // repeated start from the middle of a write into a read
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h11, ack);
    bus_start();
    send_byte(8'hD3, ack);  chk("R8 repeated start address ack", 32'(ack), 32'd1);
    rd_expect(8'h01, 1'b0, "R8 count after repeated start");
    bus_stop();

    // clear source bit: code falls back to captured straps, not live pins
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h01, ack);
    bus_stop();
    chk("R11 code back to straps R10", 32'(freq_code), 32'h5);
    chk("R11 tristate only", {28'd0, freq_from_reg, spread_down, spread_en, outputs_tristate}, 32'h1);

    repeat (10) @(negedge clk);
    chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule